// File: doc/BRIEF.md
# Multi-format synchronous serial master

This block is a full-duplex serial port that always acts as bus master towards one attached slave. It moves words of 4 to 16 bits out on a transmit line, most significant bit first. On the same bit clock it samples a receive line, so every word it sends yields exactly one received word. The bit clock is low between transfers and toggles only while a word is being moved. A frame output marks each word in one of three selectable styles: an SPI-style active-low enable, a TI-SSP-style one-bit-clock pulse ahead of the data, or a Microwire-style exchange in which an 8-bit command goes out and a data word comes back.

Software sees four 16-bit registers on a plain write/read strobe interface. One is a data window that pushes into a 16-entry transmit FIFO and pops from a 16-entry receive FIFO. The others are a control register, a 12-bit divider register and a status register. Received words are right-justified. The bit rate is the selected source clock (the internal clock, or an external clock input resynchronised into the internal domain) divided by 2×(N+1). Two level outputs ask a DMA engine for bursts of 4 or 8 half-words.

Top module: `sermstr_top`

## Requirements
- R1: After reset the status register (address 3) reads 0x0011, sclk is 0, sfrm is 1 and txd is 0. Status bits: [0] transmit FIFO not full, [1] receive FIFO not empty, [2] busy (a word in flight or queued), [3] receive overrun, [4] transmit DMA request, [5] receive DMA request.
- R2: Format 0 (control bits [2:1] = 0, SPI style): sfrm is low for the whole word. There are exactly L rising bit-clock edges. txd carries the transmit word MSB first, stable at each rising edge, and rxd is sampled on each rising edge into a right-justified received word.
- R3: Format 1 (TI-SSP style): sfrm is high for exactly the first bit-clock period, with txd low in it and rxd ignored. L data bit periods with sfrm low follow, for L+1 rising edges in total.
- R4: Format 2 (Microwire style): sfrm is low for the transfer. Bits [7:0] of the transmit word go out MSB first in 8 bit periods. Then L receive periods follow with txd low, and rxd sampled in them forms the received word, for L+8 rising edges.
- R5: Word length L is control field [6:3] plus one. Field values 0 to 2 give L = 4.
- R6: sclk is 0 whenever no word is being transferred, and never rises outside a transfer.
- R7: With control bit [7] = 0, consecutive rising bit-clock edges of one word are 2×(N+1) internal clock cycles apart, where N is divider register (address 2) bits [11:0].
- R8: With control bit [7] = 1, consecutive rising edges are 2×(N+1) periods of ext_clk apart.
- R9: The transmit FIFO holds 16 words. A write to the data register (address 0) while it is full is ignored, so exactly 16 words are transmitted.
- R10: A word that completes while the receive FIFO is full and no read pops it is dropped, and status bit 3 is set. Writing 1 to status bit 3 clears it.
- R11: When a read of address 0 pops a full receive FIFO in the same cycle a word completes, the new word is stored at the tail and no overrun is flagged.
- R12: Control bit [8] selects a burst of 8 (1) or 4 (0). tx_dma_req is high while free transmit entries ≥ burst, and rx_dma_req is high while stored receive entries ≥ burst.
- R13: With control bit [0] = 0 no transfer starts: queued words stay, busy stays 1 and sclk stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops the receive FIFO at address 0) |
| addr | input | 2 | Register address: 0 data, 1 control, 2 divider, 3 status |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the addressed register |
| ext_clk | input | 1 | Optional external bit-clock source |
| rxd | input | 1 | Serial receive data from the slave |
| sclk | output | 1 | Bit clock to the slave |
| sfrm | output | 1 | Frame signal to the slave |
| txd | output | 1 | Serial transmit data to the slave |
| tx_dma_req | output | 1 | Transmit burst request |
| rx_dma_req | output | 1 | Receive burst request |

## Verification
The receive FIFO can be popped by a software read in the same cycle the shifter pushes a finished word into it, and that race matters most when the FIFO is full. The bench fills the receive FIFO with 16 words at divider 0 and queues one more word. It watches the bit clock until the last rising edge of that word, then asserts the pop so that it lands on the edge where the shifter completes. The test passes if the overrun flag stays clear and the next 16 reads return the words that followed the popped one, ending with the new word.

// File: rtl/sermstr_pkg.sv
package sermstr_pkg;

  localparam int DATA_W   = 16;
  localparam int SLOT_W   = 5;
  localparam int CMD_BITS = 8;

  typedef enum logic [1:0] {
    FMT_SPI = 2'd0,
    FMT_TI  = 2'd1,
    FMT_MW  = 2'd2,
    FMT_RSV = 2'd3
  } fmt_e;

  // control field -> word length, lengths below 4 are raised to 4
  function automatic logic [SLOT_W-1:0] word_len(input logic [3:0] field);
    return (field < 4'd3) ? SLOT_W'(4) : SLOT_W'(field) + SLOT_W'(1);
  endfunction

  // number of bit periods a word occupies on the wire
  function automatic logic [SLOT_W-1:0] slot_total(input fmt_e f, input logic [SLOT_W-1:0] len);
    case (f)
      FMT_TI:  return len + SLOT_W'(1);
      FMT_MW:  return len + SLOT_W'(CMD_BITS);
      default: return len;
    endcase
  endfunction

  // bit driven on txd during slot s
  function automatic logic tx_bit(input fmt_e f, input logic [SLOT_W-1:0] len,
                                  input logic [DATA_W-1:0] w, input logic [SLOT_W-1:0] s);
    logic [SLOT_W-1:0] idx;
    tx_bit = 1'b0;
    idx    = '0;
    case (f)
      FMT_TI: if (s != '0) begin
        idx    = len - s;
        tx_bit = w[idx[3:0]];
      end
      FMT_MW: if (s < SLOT_W'(CMD_BITS)) begin
        idx    = SLOT_W'(CMD_BITS - 1) - s;
        tx_bit = w[idx[3:0]];
      end
      default: begin
        idx    = len - SLOT_W'(1) - s;
        tx_bit = w[idx[3:0]];
      end
    endcase
  endfunction

  // whether rxd is captured in slot s
  function automatic logic rx_slot(input fmt_e f, input logic [SLOT_W-1:0] s);
    case (f)
      FMT_TI:  return s != '0;
      FMT_MW:  return s >= SLOT_W'(CMD_BITS);
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] len_mask(input logic [SLOT_W-1:0] len);
    return {DATA_W{1'b1}} >> (SLOT_W'(DATA_W) - len);
  endfunction

endpackage

// File: rtl/sermstr_fifo.sv
module sermstr_fifo #(
  parameter int W = 16,
  parameter int D = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push,
  input  logic [W-1:0]           din,
  input  logic                   pop,
  output logic [W-1:0]           dout,
  output logic                   full,
  output logic                   empty,
  output logic [$clog2(D+1)-1:0] count
);
  localparam int AW = (D > 1) ? $clog2(D) : 1;
  localparam int CW = $clog2(D + 1);

  logic [W-1:0]  mem [D];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(D));
  assign empty   = (cnt == '0);
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign dout    = mem[rp];
  assign count   = cnt;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(D - 1)) ? '0 : wp + AW'(1);
      if (do_pop)  rp <= (rp == AW'(D - 1)) ? '0 : rp + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  // R9: occupancy never exceeds the depth
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(D));
  // R10: a push into a full FIFO without a pop leaves it full
  p_full_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> full);

endmodule

// File: rtl/sermstr_clkgen.sv
module sermstr_clkgen #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_clk,
  input  logic             use_ext,
  input  logic [DIV_W-1:0] div,
  input  logic             run,
  output logic             tick
);
  logic [2:0]       sync_q;
  logic             ext_rise, src_en;
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], ext_clk};
  end

  assign ext_rise = sync_q[1] & ~sync_q[2];
  assign src_en   = use_ext ? ext_rise : 1'b1;
  assign tick     = run && src_en && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (src_en) cnt <= (cnt == div) ? '0 : cnt + DIV_W'(1);
  end

endmodule

// File: rtl/sermstr_shifter.sv
module sermstr_shifter
  import sermstr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  fmt_e              fmt_in,
  input  logic [SLOT_W-1:0] len_in,
  input  logic              tick,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_word,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_word,
  input  logic              rxd,
  output logic              sclk,
  output logic              sfrm,
  output logic              txd,
  output logic              active
);
  logic              act_q, ph_q, sclk_q;
  logic [SLOT_W-1:0] slot_q, len_q;
  fmt_e              fmt_q;
  logic [DATA_W-1:0] word_q, rxsh_q;
  logic              start, last_slot, word_done;

  assign start     = !act_q && en && tx_valid;
  assign last_slot = (slot_q == slot_total(fmt_q, len_q) - SLOT_W'(1));
  assign word_done = act_q && tick && ph_q && last_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      ph_q   <= 1'b0;
      sclk_q <= 1'b0;
      slot_q <= '0;
      len_q  <= SLOT_W'(4);
      fmt_q  <= FMT_SPI;
      word_q <= '0;
      rxsh_q <= '0;
    end else if (!act_q) begin
      sclk_q <= 1'b0;
      if (start) begin
        act_q  <= 1'b1;
        ph_q   <= 1'b0;
        slot_q <= '0;
        len_q  <= len_in;
        fmt_q  <= fmt_in;
        word_q <= tx_word;
        rxsh_q <= '0;
      end
    end else if (tick) begin
      if (!ph_q) begin
        ph_q   <= 1'b1;
        sclk_q <= 1'b1;
        if (rx_slot(fmt_q, slot_q)) rxsh_q <= {rxsh_q[DATA_W-2:0], rxd};
      end else begin
        ph_q   <= 1'b0;
        sclk_q <= 1'b0;
        if (last_slot) act_q  <= 1'b0;
        else           slot_q <= slot_q + SLOT_W'(1);
      end
    end
  end

  assign tx_pop  = start;
  assign rx_push = word_done;
  assign rx_word = rxsh_q & len_mask(len_q);
  assign sclk    = sclk_q;
  assign active  = act_q;
  assign txd     = act_q && tx_bit(fmt_q, len_q, word_q, slot_q);
  assign sfrm    = (fmt_q == FMT_TI) ? (act_q && slot_q == '0) : !act_q;

  // R6: bit clock is low whenever the shifter is idle
  p_sclk_idle_r6: assert property (@(posedge clk) disable iff (!rst_n) !act_q |-> !sclk_q);
  // R6: bit clock rises only inside a transfer
  p_sclk_rise_r6: assert property (@(posedge clk) disable iff (!rst_n) $rose(sclk_q) |-> act_q);
  // R2: a word completes at the end of a high bit-clock phase
  p_done_high_r2: assert property (@(posedge clk) disable iff (!rst_n) word_done |-> sclk_q);

endmodule

// File: rtl/sermstr_top.sv
module sermstr_top
  import sermstr_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int DIV_W      = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic        ext_clk,
  input  logic        rxd,
  output logic        sclk,
  output logic        sfrm,
  output logic        txd,
  output logic        tx_dma_req,
  output logic        rx_dma_req
);
  localparam int CW     = $clog2(FIFO_DEPTH + 1);
  localparam int CTRL_W = 9;

  logic [CTRL_W-1:0] ctrl_q;
  logic [DIV_W-1:0]  div_q;
  logic              ovr_q;

  logic              tx_push, tx_pop, tx_full, tx_empty;
  logic              rx_push, rx_pop, rx_full, rx_empty;
  logic [DATA_W-1:0] tx_head, rx_head, rx_word;
  logic [CW-1:0]     tx_cnt, rx_cnt, burst;
  logic              tick, active, busy, ovr_set, ovr_clr;
  logic [15:0]       status;

  assign tx_push = wr_en && addr == 2'd0;
  assign rx_pop  = rd_en && addr == 2'd0;
  assign ovr_set = rx_push && rx_full && !rx_pop;
  assign ovr_clr = wr_en && addr == 2'd3 && wdata[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      div_q  <= '0;
      ovr_q  <= 1'b0;
    end else begin
      if (wr_en && addr == 2'd1) ctrl_q <= wdata[CTRL_W-1:0];
      if (wr_en && addr == 2'd2) div_q  <= wdata[DIV_W-1:0];
      if (ovr_set)      ovr_q <= 1'b1;
      else if (ovr_clr) ovr_q <= 1'b0;
    end
  end

  sermstr_fifo #(.W(DATA_W), .D(FIFO_DEPTH)) tx_fifo_i (
    .clk, .rst_n, .push(tx_push), .din(wdata), .pop(tx_pop),
    .dout(tx_head), .full(tx_full), .empty(tx_empty), .count(tx_cnt));

  sermstr_fifo #(.W(DATA_W), .D(FIFO_DEPTH)) rx_fifo_i (
    .clk, .rst_n, .push(rx_push), .din(rx_word), .pop(rx_pop),
    .dout(rx_head), .full(rx_full), .empty(rx_empty), .count(rx_cnt));

  sermstr_clkgen #(.DIV_W(DIV_W)) clkgen_i (
    .clk, .rst_n, .ext_clk, .use_ext(ctrl_q[7]), .div(div_q), .run(active), .tick);

  sermstr_shifter shifter_i (
    .clk, .rst_n, .en(ctrl_q[0]), .fmt_in(fmt_e'(ctrl_q[2:1])),
    .len_in(word_len(ctrl_q[6:3])), .tick, .tx_valid(!tx_empty), .tx_word(tx_head),
    .tx_pop, .rx_push, .rx_word, .rxd, .sclk, .sfrm, .txd, .active);

  assign busy       = active || !tx_empty;
  assign burst      = ctrl_q[8] ? CW'(8) : CW'(4);
  assign tx_dma_req = (CW'(FIFO_DEPTH) - tx_cnt) >= burst;
  assign rx_dma_req = rx_cnt >= burst;
  assign status     = {10'd0, rx_dma_req, tx_dma_req, ovr_q, busy, !rx_empty, !tx_full};

  always_comb begin
    case (addr)
      2'd0:    rdata = rx_head;
      2'd1:    rdata = 16'(ctrl_q);
      2'd2:    rdata = 16'(div_q);
      default: rdata = status;
    endcase
  end

  // R10: overrun only rises when a finished word met a full receive FIFO
  p_ovr_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(rx_full) && $past(rx_push));
  // R11: a same-cycle pop and push on a full FIFO keeps it full without overrun
  p_swap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && rx_push && rx_pop) |=> rx_full && $stable(ovr_q));

endmodule

// File: tb/sermstr_top_tb_top.sv
module sermstr_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic        ext_clk = 1'b0;
  logic        rxd;
  logic        sclk, sfrm, txd, tx_dma_req, rx_dma_req;

  int tests = 0, fails = 0;
  int rise_cnt = 0, ncyc = 0, first_cyc = 0, last_cyc = 0, wd = 0;
  logic sclk_prev = 1'b0;
  logic tx_cap [32];
  logic frm_cap [32];
  int cur_fmt = 0, cur_len = 8, cur_nsl = 8;
  logic [15:0] slv_base = 16'h0;

  always #10 clk = ~clk;
  initial begin
    #7;
    forever #40 ext_clk = ~ext_clk;
  end

  function automatic int nslots(input int f, input int l);
    if (f == 1) return l + 1;
    if (f == 2) return l + 8;
    return l;
  endfunction

  function automatic logic exp_tx(input int f, input int l, input logic [15:0] w, input int i);
    if (f == 2) return (i < 8) ? w[7-i] : 1'b0;
    if (f == 1) return (i == 0) ? 1'b0 : w[l-i];
    return w[l-1-i];
  endfunction

  function automatic logic slave_bit(input int f, input int l, input logic [15:0] w, input int i);
    if (f == 1) return (i >= 1 && i <= l) ? w[l-i] : 1'b0;
    if (f == 2) return (i >= 8 && i < 8 + l) ? w[l+7-i] : 1'b0;
    return (i < l) ? w[l-1-i] : 1'b0;
  endfunction

  function automatic logic [15:0] lmask(input int l);
    return 16'((32'd1 << l) - 1);
  endfunction

  assign rxd = slave_bit(cur_fmt, cur_len, slv_base + 16'(rise_cnt / cur_nsl), rise_cnt % cur_nsl);

  sermstr_top dut_i (
    .clk, .rst_n, .wr_en, .rd_en, .addr, .wdata, .rdata, .ext_clk, .rxd,
    .sclk, .sfrm, .txd, .tx_dma_req, .rx_dma_req);

  // bit-clock monitor acting as the slave's view of the wire
  always @(negedge clk) begin
    ncyc++;
    if (sclk && !sclk_prev) begin
      if (rise_cnt < 32) begin
        tx_cap[rise_cnt]  = txd;
        frm_cap[rise_cnt] = sfrm;
      end
      if (rise_cnt == 0) first_cyc = ncyc;
      last_cyc = ncyc;
      rise_cnt++;
    end
    sclk_prev = sclk;
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired act=%0d exp=<150000", wd);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic pop_rx(output logic [15:0] v);
    @(negedge clk);
    addr = 2'd0;
    #1 v = rdata;
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    for (int k = 0; k < 8000; k++) begin
      peek(2'd3, v);
      if (!v[2]) break;
    end
  endtask

  function automatic logic [15:0] ctrl_word(input int f, input int field, input bit ext, input bit b8, input bit en);
    return {7'd0, b8, ext, 4'(field), 2'(f), en};
  endfunction

  task automatic run_word(input int f, input int field, input int l, input int dv, input bit ext,
                          input logic [15:0] txw, input logic [15:0] slv);
    int n, per, rc;
    bit txok, frok;
    logic [15:0] v;
    string fn;
    fn  = (f == 0) ? "R2" : (f == 1) ? "R3" : "R4";
    n   = nslots(f, l);
    per = 2 * (dv + 1) * (ext ? 4 : 1);
    bus_wr(2'd2, 16'(dv));
    bus_wr(2'd1, ctrl_word(f, field, ext, 1'b0, 1'b1));
    cur_fmt = f; cur_len = l; cur_nsl = n; slv_base = slv; rise_cnt = 0;
    bus_wr(2'd0, txw);
    wait_idle();
    chk({fn, " rising edge count"}, rise_cnt, n);
    txok = 1'b1; frok = 1'b1;
    for (int i = 0; i < n; i++) begin
      if (tx_cap[i] !== exp_tx(f, l, txw, i)) txok = 1'b0;
      if (frm_cap[i] !== ((f == 1) && (i == 0))) frok = 1'b0;
    end
    chk({fn, " txd bits"}, txok, 1'b1);
    chk({fn, " sfrm shape"}, frok, 1'b1);
    chk(ext ? "R8 ext period" : "R7 int period", last_cyc - first_cyc, (n - 1) * per);
    pop_rx(v);
    chk({fn, " R5 rx word"}, v, slv & lmask(l));
    rc = rise_cnt;
    repeat (12) @(negedge clk);
    chk("R6 idle clock", {rise_cnt == rc, sclk}, 2'b10);
  endtask

  initial begin
    logic [15:0] v, b;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    peek(2'd3, v);
    chk("R1 status", v, 16'h0011);
    chk("R1 pins", {sclk, sfrm, txd}, 3'b010);

    // R13, R12, R9: queue words while disabled
    bus_wr(2'd2, 16'd0);
    bus_wr(2'd1, ctrl_word(0, 7, 1'b0, 1'b1, 1'b0));
    cur_fmt = 0; cur_len = 8; cur_nsl = 8; slv_base = 16'h0040; rise_cnt = 0;
    for (int k = 0; k < 8; k++) bus_wr(2'd0, 16'(16'h00A0 + k));
    chk("R12 tx req at 8 free", tx_dma_req, 1'b1);
    bus_wr(2'd0, 16'h00A8);
    chk("R12 tx req at 7 free", tx_dma_req, 1'b0);
    for (int k = 9; k < 16; k++) bus_wr(2'd0, 16'(16'h00A0 + k));
    peek(2'd3, v);
    chk("R9 tx full flag", v[0], 1'b0);
    bus_wr(2'd0, 16'hDEAD);
    repeat (40) @(negedge clk);
    peek(2'd3, v);
    chk("R13 disabled holds", {rise_cnt == 0, sclk, v[2]}, 3'b101);
    bus_wr(2'd1, ctrl_word(0, 7, 1'b0, 1'b1, 1'b1));
    wait_idle();
    chk("R9 sixteen words sent", rise_cnt, 128);
    peek(2'd3, v);
    chk("R12 status after fill", v[5:1], 5'b11001);

    // R10: one more word into a full receive FIFO
    bus_wr(2'd0, 16'h0011);
    wait_idle();
    peek(2'd3, v);
    chk("R10 overrun set", v[3], 1'b1);
    for (int k = 0; k < 16; k++) begin
      pop_rx(v);
      chk("R10 kept word", v, (16'h0040 + 16'(k)) & 16'h00FF);
      if (k == 8) chk("R12 rx req below burst", rx_dma_req, 1'b0);
    end
    bus_wr(2'd3, 16'h0008);
    peek(2'd3, v);
    chk("R10 overrun cleared", v[3], 1'b0);

    // R11: pop and push collide on a full receive FIFO
    bus_wr(2'd1, ctrl_word(0, 7, 1'b0, 1'b0, 1'b0));
    slv_base = 16'h0070; rise_cnt = 0;
    for (int k = 0; k < 16; k++) bus_wr(2'd0, 16'(k));
    bus_wr(2'd1, ctrl_word(0, 7, 1'b0, 1'b0, 1'b1));
    wait_idle();
    bus_wr(2'd0, 16'h0033);
    wait (rise_cnt == 136);
    addr = 2'd0;
    #1 b = rdata;
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R11 popped head", b, 16'h0070);
    wait_idle();
    peek(2'd3, v);
    chk("R11 no overrun", v[3], 1'b0);
    for (int k = 1; k <= 16; k++) begin
      pop_rx(v);
      chk("R11 order", v, (16'h0070 + 16'(k)) & 16'h00FF);
    end

    // R5: short length fields clamp to 4 bits
    run_word(0, 1, 4, 0, 1'b0, 16'h000B, 16'h0FF6);
    run_word(2, 0, 4, 1, 1'b0, 16'h00C5, 16'h0009);

    // directed: full 16-bit words in each format, one on the external clock
    run_word(0, 15, 16, 2, 1'b0, 16'hA55A, 16'h3C96);
    run_word(1, 15, 16, 0, 1'b1, 16'h8001, 16'hFFFE);
    run_word(2, 15, 16, 3, 1'b0, 16'h00FF, 16'h8421);

    // constrained random words
    for (int t = 0; t < 24; t++) begin
      int f, l, dv;
      bit ext;
      f   = int'($urandom % 3);
      l   = 4 + int'($urandom % 13);
      dv  = int'($urandom % 4);
      ext = ($urandom % 4) == 0;
      run_word(f, l - 1, l, dv, ext, 16'($urandom), 16'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule